// File: doc/BRIEF.md
# Serial Line-Interface Control Port

This block is a four-wire serial slave that lets a microcontroller program a line-card controller. The host lowers chip select, clocks exactly one byte, and raises chip select again. There is no address phase. A byte whose first bit is 1 is always a configuration byte. A byte whose first bit is 0 goes to a target chosen by fields of the most recent configuration byte: one of eight slot registers (transmit or receive, for four channels), or one of four per-channel line-interface control registers.

One configuration pattern (bits 6:4 = 101) also arms a status read. The transaction that follows it shifts out the status byte of the selected channel on the data output. During that read, the data input is ignored.

Each channel drives three signaling outputs and two bidirectional signaling pins from its control register. The pin states are sampled through a two-flop synchronizer into the status bytes. Serial inputs are oversampled by the system clock, so every register sits in one clock domain.

Top module: `slic_serial_ctrl`

## Requirements
- R1: A transaction commits only if exactly 8 falling serial-clock edges occur while chip select is low. The commit happens when chip select rises. A transaction with fewer or more edges changes no register and leaves a pending status read armed.
- R2: `sdo_en_o` is 0 whenever `cs_ni` is high, and it is 1 only during a status-read transaction.
- R3: A committed byte whose first bit (bit 7) is 1 is loaded whole into `cfg_o`. Bytes are received most significant bit first, sampled on falling serial-clock edges.
- R4: A committed byte with bit 7 = 0, when cfg bit 6 = 0 and cfg bit 1 = 0, is written to the slot register with index 2*cfg[3:2] + cfg[0], where cfg[0] = 0 selects transmit and 1 selects receive. Slot register k appears on `slot_o[8k+7:8k]`.
- R5: A committed byte with bit 7 = 0, when cfg[6:4] = 101 and no read is pending, is written to the control register of channel cfg[3:2].
- R6: A configuration write with bits 6:4 = 101 makes the next complete transaction a read. That read shifts out the selected channel's status byte, most significant bit first, one bit per rising serial-clock edge. The bits clocked in during the read change no register.
- R7: For channel c, with control register byte b: `sig_o[3c+k]` = b[k] for k = 0..2; `io_o[2c+j]` = b[3+j`]`; `io_oe_o[2c+j]` = b[5+j] for j = 0..1. Bit 7 of b is unused.
- R8: The status byte of channel c is {pin 2c+1, pin 2c, b[2:0], pin 2, pin 4, pin 6}, where pin n is the synchronized `io_i[n]`. The byte is captured when chip select falls and stays unchanged while it is shifted out.
- R9: After reset, `cfg_o`, `slot_o`, `sig_o`, `io_o` and `io_oe_o` are all 0, all bidirectional pins are inputs, and no read is pending. A cfg value of 0 means A-law, delayed timing and all channels in standby.
- R10: A committed byte with bit 7 = 0 is discarded in two cases: when cfg bit 6 = 0 and cfg bit 1 = 1, and when cfg bit 6 = 1 and cfg[6:4] is not 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data out of the block |
| sdo_en_o | output | 1 | Output enable for the tri-state data output |
| cfg_o | output | 8 | Configuration register |
| slot_o | output | 64 | Eight slot registers, packed |
| sig_o | output | 12 | Signaling outputs, three per channel |
| io_o | output | 8 | Bidirectional pin drive values, two per channel |
| io_oe_o | output | 8 | Bidirectional pin output enables |
| io_i | input | 8 | Bidirectional pin levels as seen on the pads |

## Verification
The hardest behaviours to reach from the ports are the status snapshot and the pending-read flag.

For the snapshot, the bench models the pads: each bidirectional pin follows the block's drive value when its enable is set, and otherwise follows an external value. Part-way through a read, the bench inverts the external values, and the shifted byte must still match the value captured when chip select fell.

For the pending-read flag, the bench aborts a transaction after a few bits, both before and during an armed read. It then checks that no register moved and that the next complete transaction is still the read.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int NUM_CH    = 4;
  localparam int SIG_OUT   = 3;
  localparam int SIG_IO    = 2;
  localparam int BYTE_W    = 8;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int SLOT_N    = 2 * NUM_CH;
  localparam int CNT_W     = $clog2(BYTE_W + 2);
  localparam int IO_N      = NUM_CH * SIG_IO;
  localparam int CTL_IO_LSB  = SIG_OUT;
  localparam int CTL_DIR_LSB = SIG_OUT + SIG_IO;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t      CFG_RST  = '0;
  localparam logic [2:0] SEL_SLIC = 3'b101;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ssc_frame.sv
module ssc_frame
  import ssc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_n_i,
  input  logic  sclk_i,
  input  logic  sdi_i,
  input  byte_t tx_i,
  output logic  start_o,
  output logic  stop_o,
  output logic  done_o,
  output byte_t rx_o,
  output logic  sdo_o
);
  logic             cs_q, sclk_q, sdo_q;
  logic [CNT_W-1:0] cnt_q;
  byte_t            rx_q, tx_q;
  logic             fall, rise;

  assign start_o = cs_q & ~cs_n_i;
  assign stop_o  = ~cs_q & cs_n_i;
  assign fall    = ~cs_n_i & sclk_q & ~sclk_i;
  assign rise    = ~cs_n_i & ~sclk_q & sclk_i;
  assign done_o  = stop_o & (cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
      if (start_o) begin
        cnt_q <= '0;
        tx_q  <= tx_i;  // status snapshot
      end else begin
        if (fall) begin
          rx_q <= {rx_q[BYTE_W-2:0], sdi_i};
          if (cnt_q != CNT_W'(BYTE_W + 1)) cnt_q <= cnt_q + 1'b1;
        end
        if (rise) begin
          sdo_q <= tx_q[BYTE_W-1];
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_o  = rx_q;
  assign sdo_o = sdo_q;
endmodule

// File: rtl/ssc_regs.sv
module ssc_regs
  import ssc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     done_i,
  input  byte_t                    rx_i,
  output byte_t                    cfg_o,
  output logic [SLOT_N*BYTE_W-1:0] slot_o,
  output logic [NUM_CH*BYTE_W-1:0] ctl_o,
  output logic                     rd_act_o
);
  byte_t             cfg_q;
  byte_t             slot_q [SLOT_N];
  byte_t             ctl_q  [NUM_CH];
  logic              rd_pend_q, rd_act_q;
  logic [CH_W-1:0]   ch_sel;
  logic [CH_W:0]     slot_sel;

  assign ch_sel   = cfg_q[2 +: CH_W];
  assign slot_sel = {ch_sel, cfg_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CFG_RST;
      rd_pend_q <= 1'b0;
      rd_act_q  <= 1'b0;
      for (int i = 0; i < SLOT_N; i++) slot_q[i] <= '0;
      for (int i = 0; i < NUM_CH; i++) ctl_q[i]  <= '0;
    end else begin
      if (start_i) rd_act_q <= rd_pend_q;
      if (done_i) begin
        if (rd_act_q) begin
          rd_pend_q <= 1'b0;
        end else if (rx_i[BYTE_W-1]) begin
          cfg_q     <= rx_i;
          rd_pend_q <= (rx_i[6:4] == SEL_SLIC);
        end else if (!cfg_q[6]) begin
          if (!cfg_q[1]) slot_q[slot_sel] <= rx_i;
        end else if (cfg_q[6:4] == SEL_SLIC) begin
          ctl_q[ch_sel] <= rx_i;
        end
      end
      if (stop_i) rd_act_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    assign slot_o[s*BYTE_W +: BYTE_W] = slot_q[s];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    assign ctl_o[c*BYTE_W +: BYTE_W] = ctl_q[c];
  end

  assign cfg_o    = cfg_q;
  assign rd_act_o = rd_act_q;
endmodule

// File: rtl/ssc_pins.sv
module ssc_pins
  import ssc_pkg::*;
(
  input  logic [NUM_CH*BYTE_W-1:0]  ctl_i,
  input  logic [IO_N-1:0]           pad_i,
  input  logic [CH_W-1:0]           ch_sel_i,
  output logic [NUM_CH*SIG_OUT-1:0] sig_o,
  output logic [IO_N-1:0]           io_o,
  output logic [IO_N-1:0]           io_oe_o,
  output byte_t                     status_o
);
  byte_t              st [NUM_CH];
  logic [NUM_CH-2:0]  shared;

  // low status bits: pin 0 of channels 1..N-1, lowest channel highest
  for (genvar k = 1; k < NUM_CH; k++) begin : g_shared
    assign shared[NUM_CH-1-k] = pad_i[k*SIG_IO];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [BYTE_W-1:0] b;
    assign b = ctl_i[c*BYTE_W +: BYTE_W];
    assign sig_o[c*SIG_OUT +: SIG_OUT]  = b[SIG_OUT-1:0];
    assign io_o[c*SIG_IO +: SIG_IO]     = b[CTL_IO_LSB +: SIG_IO];
    assign io_oe_o[c*SIG_IO +: SIG_IO]  = b[CTL_DIR_LSB +: SIG_IO];
    assign st[c] = {pad_i[c*SIG_IO+1], pad_i[c*SIG_IO], b[SIG_OUT-1:0], shared};
  end

  assign status_o = st[ch_sel_i];
endmodule

// File: rtl/slic_serial_ctrl.sv
module slic_serial_ctrl
  import ssc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_ni,
  input  logic                      sclk_i,
  input  logic                      sdi_i,
  output logic                      sdo_o,
  output logic                      sdo_en_o,
  output logic [BYTE_W-1:0]         cfg_o,
  output logic [SLOT_N*BYTE_W-1:0]  slot_o,
  output logic [NUM_CH*SIG_OUT-1:0] sig_o,
  output logic [IO_N-1:0]           io_o,
  output logic [IO_N-1:0]           io_oe_o,
  input  logic [IO_N-1:0]           io_i
);
  logic [2:0]               ser_s;
  logic [IO_N-1:0]          pad_s;
  logic                     start, stop, done, rd_act, sdo_bit;
  byte_t                    rx, status, cfg;
  logic [NUM_CH*BYTE_W-1:0] ctl;

  ssc_sync #(.W(3), .RST_VAL(3'b100)) u_ser_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sclk_i, sdi_i}), .q_o(ser_s)
  );

  ssc_sync #(.W(IO_N), .RST_VAL('0)) u_pad_sync (
    .clk_i, .rst_ni, .d_i(io_i), .q_o(pad_s)
  );

  ssc_frame u_frame (
    .clk_i, .rst_ni,
    .cs_n_i(ser_s[2]), .sclk_i(ser_s[1]), .sdi_i(ser_s[0]),
    .tx_i(status), .start_o(start), .stop_o(stop), .done_o(done),
    .rx_o(rx), .sdo_o(sdo_bit)
  );

  ssc_regs u_regs (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .done_i(done),
    .rx_i(rx), .cfg_o(cfg), .slot_o(slot_o), .ctl_o(ctl), .rd_act_o(rd_act)
  );

  ssc_pins u_pins (
    .ctl_i(ctl), .pad_i(pad_s), .ch_sel_i(cfg[2 +: CH_W]),
    .sig_o(sig_o), .io_o(io_o), .io_oe_o(io_oe_o), .status_o(status)
  );

  assign cfg_o    = cfg;
  assign sdo_en_o = ~cs_ni & rd_act;
  assign sdo_o    = sdo_en_o & sdo_bit;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
  import ssc_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cs_ni,
  input logic                      sdo_en_o,
  input logic [BYTE_W-1:0]         cfg_o,
  input logic [SLOT_N*BYTE_W-1:0]  slot_o,
  input logic [NUM_CH*SIG_OUT-1:0] sig_o,
  input logic [IO_N-1:0]           io_o,
  input logic [IO_N-1:0]           io_oe_o
);
  p_hiz_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_en_o);

  p_cfg_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o != $past(cfg_o)) |-> cfg_o[BYTE_W-1]);

  p_slot_commit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != $past(slot_o)) |-> cs_ni);

  p_ctl_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({sig_o, io_o, io_oe_o} != $past({sig_o, io_o, io_oe_o})) |-> cs_ni);

  p_no_drive_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |=> $stable({sig_o, io_o, io_oe_o, slot_o, cfg_o}));
endmodule

bind slic_serial_ctrl ssc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdo_en_o(sdo_en_o),
  .cfg_o(cfg_o), .slot_o(slot_o), .sig_o(sig_o), .io_o(io_o), .io_oe_o(io_oe_o)
);

// File: tb/slic_serial_ctrl_bench.sv
module slic_serial_ctrl_bench;
  logic        clk = 0, rst_ni = 0;
  logic        cs_ni = 1, sclk = 0, sdi = 0;
  logic        sdo, sdo_en;
  logic [7:0]  cfg;
  logic [63:0] slot;
  logic [11:0] sig;
  logic [7:0]  io_o, io_oe, io_pad, ext_io;
  logic        flip_mid = 0, finished = 0;
  int          n_chk = 0, n_fail = 0;

  logic [7:0]  slot_m [8];
  logic [7:0]  ctl_m  [4];

  always #5 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pad
    assign io_pad[i] = io_oe[i] ? io_o[i] : ext_io[i];
  end

  slic_serial_ctrl u_slic_serial_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .cfg_o(cfg), .slot_o(slot),
    .sig_o(sig), .io_o(io_o), .io_oe_o(io_oe), .io_i(io_pad)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] din, input int nbits,
                      output logic [7:0] dout, output logic en_all, output logic en_any);
    @(negedge clk);
    cs_ni = 0;
    repeat (4) @(negedge clk);
    dout = '0; en_all = 1; en_any = 0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; sdi = din[7-i];
      if (flip_mid && i == 3) ext_io = ~ext_io;
      repeat (8) @(negedge clk);
      dout = {dout[6:0], sdo};
      if (!sdo_en) en_all = 0;
      if (sdo_en) en_any = 1;
      sclk = 0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_ni = 1;
    repeat (60) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    logic [7:0] d; logic ea, en;
    xfer(b, 8, d, ea, en);
    chk("R2 write keeps output off", {63'd0, en}, 64'd0);
  endtask

  function automatic logic [63:0] slot_exp();
    logic [63:0] v;
    for (int s = 0; s < 8; s++) v[s*8 +: 8] = slot_m[s];
    return v;
  endfunction

  function automatic logic [31:0] pins_exp();
    logic [11:0] s; logic [7:0] o, e;
    for (int c = 0; c < 4; c++) begin
      s[c*3 +: 3] = ctl_m[c][2:0];
      o[c*2 +: 2] = ctl_m[c][4:3];
      e[c*2 +: 2] = ctl_m[c][6:5];
    end
    return {s, o, e, 4'd0};
  endfunction

  function automatic logic pin_m(input int n);
    return ctl_m[n/2][5 + n%2] ? ctl_m[n/2][3 + n%2] : ext_io[n];
  endfunction

  function automatic logic [7:0] st_exp(input int c);
    return {pin_m(2*c+1), pin_m(2*c), ctl_m[c][2:0], pin_m(2), pin_m(4), pin_m(6)};
  endfunction

  task automatic rd_status(input int c, input string req);
    logic [7:0] d, e; logic ea, en;
    wr(8'hD0 | 8'(c << 2));
    e = st_exp(c);
    xfer(8'h00, 8, d, ea, en);
    chk({req, " status byte"}, {56'd0, d}, {56'd0, e});
    chk("R2 output enabled across read", {63'd0, ea}, 64'd1);
    chk("R6 read leaves control intact", {32'd0, sig, io_o, io_oe, 4'd0}, {32'd0, pins_exp()});
  endtask

  initial begin
    logic [7:0] d; logic ea, en;
    ext_io = 8'h00;
    for (int s = 0; s < 8; s++) slot_m[s] = '0;
    for (int c = 0; c < 4; c++) ctl_m[c] = '0;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9 cfg reset", {56'd0, cfg}, 64'd0);
    chk("R9 slot reset", slot, 64'd0);
    chk("R9 pins reset", {32'd0, sig, io_o, io_oe, 4'd0}, 64'd0);
    chk("R2 idle output off", {63'd0, sdo_en}, 64'd0);

    // R3/R4 sweep of every slot register
    for (int c = 0; c < 4; c++) begin
      for (int dr = 0; dr < 2; dr++) begin
        logic [7:0] cv, val;
        cv  = 8'h80 | 8'(c << 2) | 8'(dr);
        val = 8'((c * 37 + dr * 11 + 5) & 8'h7F);
        wr(cv);
        chk("R3 cfg load", {56'd0, cfg}, {56'd0, cv});
        wr(val);
        slot_m[c*2 + dr] = val;
        chk("R4 slot write", slot, slot_exp());
      end
    end

    // R10 discarded targets
    wr(8'h82); wr(8'h55);
    chk("R10 cfg bit1 set discards", slot, slot_exp());
    wr(8'hE0); wr(8'h33);
    chk("R10 cfg 110 discards slot", slot, slot_exp());
    chk("R10 cfg 110 discards ctl", {32'd0, sig, io_o, io_oe, 4'd0}, {32'd0, pins_exp()});

    // R1 incomplete transactions
    wr(8'h84);
    xfer(8'h7F, 5, d, ea, en);
    chk("R1 short write ignored", slot, slot_exp());
    xfer(8'hFF, 5, d, ea, en);
    chk("R1 short cfg ignored", {56'd0, cfg}, 64'h84);

    // R6/R5/R7 control registers: read first, then write
    begin
      logic [7:0] vals [4];
      vals[0] = 8'h65; vals[1] = 8'h3A; vals[2] = 8'h1F; vals[3] = 8'h48;
      for (int c = 0; c < 4; c++) begin
        rd_status(c, "R6");
        wr(vals[c]);
        ctl_m[c] = vals[c];
        chk("R5 R7 control to pins", {32'd0, sig, io_o, io_oe, 4'd0}, {32'd0, pins_exp()});
      end
    end

    // R1 aborted read keeps the read armed
    wr(8'hD4);
    xfer(8'h00, 4, d, ea, en);
    chk("R1 aborted read no change", {32'd0, sig, io_o, io_oe, 4'd0}, {32'd0, pins_exp()});
    begin
      logic [7:0] e;
      e = st_exp(1);
      xfer(8'h00, 8, d, ea, en);
      chk("R1 read still pending", {56'd0, d}, {56'd0, e});
    end

    // R8 sweep of external pin patterns
    for (int p = 0; p < 16; p++) begin
      ext_io = 8'(p * 29 + 3);
      rd_status(p % 4, "R8");
    end

    // R8 snapshot holds while pins change mid-read
    ext_io = 8'hA5;
    flip_mid = 1;
    rd_status(2, "R8 snapshot");
    rd_status(3, "R8 snapshot");
    flip_mid = 0;

    // R5 control write goes to channel after read completes
    wr(8'hD8); xfer(8'h00, 8, d, ea, en);
    wr(8'h00); ctl_m[2] = 8'h00;
    chk("R5 clear channel 2", {32'd0, sig, io_o, io_oe, 4'd0}, {32'd0, pins_exp()});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule